// File: doc/BRIEF.md
# Chained Transfer Descriptor Walker

This block follows a linked chain of transfer descriptors in a local data memory and hands a decoded request for each one to a downstream data mover. Software loads the address of the first descriptor into a pointer register and writes a start strobe. The walker then reads the seven words of the descriptor one per cycle through a read port that has one cycle of latency. The words are, in order: link word, control word, sample count, DSP address, buffer offset, buffer base and buffer size.

The control word is split into transfer attributes: interleave, direction, offset writeback, buffer select, sample format and address step. These attributes and the five data words are held on the request port until the mover accepts them. The walker then waits for the mover's completion pulse. If bit 14 of the link word is clear, the low address bits of the link word become the new pointer and the next descriptor is fetched. If bit 14 is set, the chain ends. The walker goes idle and a sticky end-of-list flag raises the interrupt output. Software clears that flag by writing 1 to it.

Top module: `dmaw_top`

## Requirements
- R1: After a synchronous reset, `busy`, `irq`, `xfer_valid` and `dm_rd_en` are 0.
- R2: A start strobe accepted while idle makes the walker read seven consecutive addresses, from pointer+0 to pointer+6, one per cycle with `dm_rd_en` high.
- R3: The control word (word 1) decodes as follows. Bit 0 is interleave. Bit 1 is direction. Bit 4 is offset writeback. Bits 8:5 are buffer select. Bits 12:10 are sample format. Bits 23:14 are the address step. Bits 2, 3, 9 and 13 have no effect on any output.
- R4: Words 2 to 6 appear on `xfer_count`, `xfer_dsp_addr`, `xfer_buf_offset`, `xfer_buf_base` and `xfer_buf_size`. `xfer_valid` rises after the seventh word arrives. It stays high with every field unchanged until a cycle in which `xfer_ready` is high.
- R5: Each accepted `xfer_done` loads the low ADDR_W bits of the link word into the pointer register. If link bit 14 is 0, fetching of the next descriptor starts from that address.
- R6: When `xfer_done` completes a descriptor whose link bit 14 is 1, `busy` falls, no further reads are issued, and the end-of-list flag and `irq` become 1.
- R7: Writing status register address 2 with bit 7 set clears the flag. Writing it with bit 7 clear leaves the flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: While busy, a start strobe (register address 1, bit 0 = 1) and a pointer write (register address 0) have no effect.
- R9: Register reads return data one cycle after the address is presented. Address 0 returns the pointer. Address 2 returns the flag in bit 7 and busy in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pointer, 1 start, 2 status |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Registered read data |
| dm_rd_en | output | 1 | Descriptor memory read enable |
| dm_addr | output | ADDR_W | Descriptor memory word address |
| dm_rdata | input | 24 | Descriptor memory data, one cycle after the request |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Mover accepts the request |
| xfer_interleave | output | 1 | Address interleave mode |
| xfer_dir | output | 1 | Transfer direction |
| xfer_writeback | output | 1 | Buffer offset writeback enable |
| xfer_buf_sel | output | 4 | External buffer select |
| xfer_format | output | 3 | Sample format |
| xfer_step | output | 10 | DSP address step |
| xfer_count | output | 24 | Sample count |
| xfer_dsp_addr | output | 24 | DSP start address |
| xfer_buf_offset | output | 24 | Buffer offset |
| xfer_buf_base | output | 24 | Buffer base |
| xfer_buf_size | output | 24 | Buffer size minus one |
| xfer_done | input | 1 | Mover completion pulse |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | End-of-list flag |

## Verification
Two events can land on the end-of-list flag in the same clock cycle: the completion of the final descriptor sets it, and a software write-one-to-clear clears it. The bench forces this collision by taking over the completion pulse for a single-descriptor chain. It then drives that pulse and a status write with bit 7 set during the same cycle. The check passes only if `irq` is still high afterwards and a later read of the status register shows bit 7 set.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int WORD_W     = 24;
  localparam int DESC_WORDS = 7;
  localparam int EOL_BIT    = 14;
  localparam int FLAG_BIT   = 7;

  localparam logic [1:0] RA_PTR   = 2'd0;
  localparam logic [1:0] RA_START = 2'd1;
  localparam logic [1:0] RA_STAT  = 2'd2;

  typedef struct packed {
    logic       interleave;
    logic       dir;
    logic       writeback;
    logic [3:0] buf_sel;
    logic [2:0] fmt;
    logic [9:0] step;
  } ctrl_t;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} wstate_t;
endpackage

// File: rtl/dmaw_decode.sv
module dmaw_decode
  import dmaw_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic [WW-1:0] ctrl_word,
  output ctrl_t         fields
);
  // bits 2,3,9,13 are deliberately left unused (R3)
  always_comb begin
    fields.interleave = ctrl_word[0];
    fields.dir        = ctrl_word[1];
    fields.writeback  = ctrl_word[4];
    fields.buf_sel    = ctrl_word[8:5];
    fields.fmt        = ctrl_word[12:10];
    fields.step       = ctrl_word[23:14];
  end
endmodule

// File: rtl/dmaw_regs.sv
module dmaw_regs
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WW     = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WW-1:0]     wdata,
  input  logic              busy,
  input  logic              done_pulse,
  input  logic              done_eol,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] ptr,
  output logic              start,
  output logic              flag,
  output logic [WW-1:0]     rdata
);
  logic clr_req;

  assign start   = wr_en && (addr == RA_START) && wdata[0] && !busy;
  assign clr_req = wr_en && (addr == RA_STAT) && wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      flag  <= 1'b0;
      rdata <= '0;
    end else begin
      if (done_pulse)
        ptr <= next_addr;
      else if (wr_en && (addr == RA_PTR) && !busy)
        ptr <= wdata[ADDR_W-1:0];

      if (done_eol)
        flag <= 1'b1;
      else if (clr_req)
        flag <= 1'b0;

      rdata <= '0;
      case (addr)
        RA_PTR:  rdata[ADDR_W-1:0] <= ptr;
        RA_STAT: begin
          rdata[FLAG_BIT] <= flag;
          rdata[0]        <= busy;
        end
        default: ;
      endcase
    end
  end

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_pulse) |=> $stable(ptr));
  p_eol_sets_r6: assert property (@(posedge clk) disable iff (rst)
    done_eol |=> flag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/dmaw_walker.sv
module dmaw_walker
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WW     = WORD_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [ADDR_W-1:0]               ptr,
  output logic                            dm_rd_en,
  output logic [ADDR_W-1:0]               dm_addr,
  input  logic [WW-1:0]                   dm_rdata,
  output logic [DESC_WORDS-1:0][WW-1:0]   desc,
  output logic                            xfer_valid,
  input  logic                            xfer_ready,
  input  logic                            xfer_done,
  output logic                            busy,
  output logic                            done_pulse,
  output logic                            done_eol,
  output logic [ADDR_W-1:0]               next_addr
);
  localparam int CNT_W = $clog2(DESC_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DESC_WORDS - 1);
  localparam logic [CNT_W-1:0] NWORDS   = CNT_W'(DESC_WORDS);

  wstate_t          st;
  logic [CNT_W-1:0] iss_cnt;
  logic [CNT_W-1:0] cap_idx;
  logic             cap_vld;

  assign dm_rd_en   = (st == S_FETCH) && (iss_cnt < NWORDS);
  assign dm_addr    = ptr + ADDR_W'(iss_cnt);
  assign busy       = (st != S_IDLE);
  assign xfer_valid = (st == S_ISSUE);
  assign done_pulse = (st == S_WAIT) && xfer_done;
  assign done_eol   = done_pulse && desc[0][EOL_BIT];
  assign next_addr  = desc[0][ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      iss_cnt <= '0;
      cap_idx <= '0;
      cap_vld <= 1'b0;
      desc    <= '0;
    end else begin
      cap_vld <= dm_rd_en;
      cap_idx <= iss_cnt;
      if (dm_rd_en) iss_cnt <= iss_cnt + 1'b1;
      if (cap_vld)  desc[cap_idx] <= dm_rdata;
      case (st)
        S_IDLE:  if (start) begin
                   st      <= S_FETCH;
                   iss_cnt <= '0;
                 end
        S_FETCH: if (cap_vld && (cap_idx == LAST_IDX)) st <= S_ISSUE;
        S_ISSUE: if (xfer_ready) st <= S_WAIT;
        S_WAIT:  if (xfer_done) begin
                   if (desc[0][EOL_BIT]) st <= S_IDLE;
                   else begin
                     st      <= S_FETCH;
                     iss_cnt <= '0;
                   end
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_req_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(desc)));
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (dm_rd_en && (iss_cnt != '0)) |-> (dm_addr == $past(dm_addr) + 1'b1));
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_pulse) |=> busy);
  p_quiet_after_eol_r6: assert property (@(posedge clk) disable iff (rst)
    done_eol |=> (!busy && !dm_rd_en));
endmodule

// File: rtl/dmaw_top.sv
module dmaw_top
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [23:0]       reg_wdata,
  output logic [23:0]       reg_rdata,
  output logic              dm_rd_en,
  output logic [ADDR_W-1:0] dm_addr,
  input  logic [23:0]       dm_rdata,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic              xfer_interleave,
  output logic              xfer_dir,
  output logic              xfer_writeback,
  output logic [3:0]        xfer_buf_sel,
  output logic [2:0]        xfer_format,
  output logic [9:0]        xfer_step,
  output logic [23:0]       xfer_count,
  output logic [23:0]       xfer_dsp_addr,
  output logic [23:0]       xfer_buf_offset,
  output logic [23:0]       xfer_buf_base,
  output logic [23:0]       xfer_buf_size,
  input  logic              xfer_done,
  output logic              busy,
  output logic              irq
);
  logic [ADDR_W-1:0]                 ptr, next_addr;
  logic                              start, done_pulse, done_eol;
  logic [DESC_WORDS-1:0][WORD_W-1:0] desc;
  ctrl_t                             cf;

  dmaw_regs #(.ADDR_W(ADDR_W), .WW(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .done_pulse(done_pulse),
    .done_eol(done_eol), .next_addr(next_addr), .ptr(ptr),
    .start(start), .flag(irq), .rdata(reg_rdata));

  dmaw_walker #(.ADDR_W(ADDR_W), .WW(WORD_W)) u_walk (
    .clk(clk), .rst(rst), .start(start), .ptr(ptr),
    .dm_rd_en(dm_rd_en), .dm_addr(dm_addr), .dm_rdata(dm_rdata),
    .desc(desc), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .busy(busy), .done_pulse(done_pulse),
    .done_eol(done_eol), .next_addr(next_addr));

  dmaw_decode #(.WW(WORD_W)) u_dec (.ctrl_word(desc[1]), .fields(cf));

  assign xfer_interleave = cf.interleave;
  assign xfer_dir        = cf.dir;
  assign xfer_writeback  = cf.writeback;
  assign xfer_buf_sel    = cf.buf_sel;
  assign xfer_format     = cf.fmt;
  assign xfer_step       = cf.step;
  assign xfer_count      = desc[2];
  assign xfer_dsp_addr   = desc[3];
  assign xfer_buf_offset = desc[4];
  assign xfer_buf_base   = desc[5];
  assign xfer_buf_size   = desc[6];
endmodule

// File: tb/dmaw_top_bench.sv
`timescale 1ns/1ps
module dmaw_top_bench;
  localparam int AW = 12;
  localparam int IW = 140;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic dm_rd_en;
  logic [AW-1:0] dm_addr;
  logic [23:0] dm_rdata = '0;
  logic xfer_valid, xfer_ready;
  logic xfer_interleave, xfer_dir, xfer_writeback;
  logic [3:0] xfer_buf_sel;
  logic [2:0] xfer_format;
  logic [9:0] xfer_step;
  logic [23:0] xfer_count, xfer_dsp_addr, xfer_buf_offset, xfer_buf_base, xfer_buf_size;
  logic xfer_done, busy, irq;
  logic done_auto = 1'b0, done_man = 1'b0, manual = 1'b0, bp_en = 1'b0;
  logic [23:0] mem [0:(1<<AW)-1];
  logic [IW-1:0] exp_q [$];
  logic [AW-1:0] addr_q [$];
  int n_chk = 0, n_bad = 0, hs_cnt = 0, rd_cnt = 0, cyc = 0;
  logic pend_v = 1'b0;
  logic [AW-1:0] pend_a = '0;

  assign xfer_done = done_auto | done_man;
  always #2.5 clk = ~clk;

  dmaw_top #(.ADDR_W(AW)) u_dmaw_top (.*);

  task automatic chk(input logic ok, input string req, input logic [IW-1:0] act, input logic [IW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [IW-1:0] mk_item(input logic [23:0] c, w2, w3, w4, w5, w6);
    return {c[0], c[1], c[4], c[8:5], c[12:10], c[23:14], w2, w3, w4, w5, w6};
  endfunction

  task automatic put_desc(input logic [AW-1:0] a, input logic [23:0] link, c, w2, w3, w4, w5, w6);
    logic [23:0] w [7];
    w = '{link, c, w2, w3, w4, w5, w6};
    for (int k = 0; k < 7; k++) begin
      mem[a + AW'(k)] = w[k];
      addr_q.push_back(a + AW'(k));
    end
    exp_q.push_back(mk_item(c, w2, w3, w4, w5, w6));
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  // memory model: request seen mid-cycle, data returned at the next edge
  always @(negedge clk) begin pend_v = dm_rd_en; pend_a = dm_addr; end
  always @(posedge clk) if (pend_v) dm_rdata <= mem[pend_a];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    xfer_ready <= bp_en ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: read addresses and transfer requests against the scoreboard
  always @(negedge clk) begin
    if (!rst && dm_rd_en) begin
      rd_cnt++;
      if (addr_q.size() == 0) chk(1'b0, "R2 unexpected read", IW'(dm_addr), '0);
      else begin
        logic [AW-1:0] ea;
        ea = addr_q.pop_front();
        chk(dm_addr == ea, "R2 read address", IW'(dm_addr), IW'(ea));
      end
    end
    if (!rst && xfer_valid && xfer_ready) begin
      logic [IW-1:0] act;
      act = {xfer_interleave, xfer_dir, xfer_writeback, xfer_buf_sel, xfer_format,
             xfer_step, xfer_count, xfer_dsp_addr, xfer_buf_offset, xfer_buf_base, xfer_buf_size};
      hs_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected request", act, '0);
      else begin
        logic [IW-1:0] e;
        e = exp_q.pop_front();
        chk(act == e, "R3/R4 request fields", act, e);
      end
    end
  end

  // responder: completion two cycles after acceptance
  initial forever begin
    @(negedge clk);
    if (!rst && !manual && xfer_valid && xfer_ready) begin
      repeat (2) @(negedge clk);
      done_auto = 1'b1;
      @(negedge clk);
      done_auto = 1'b0;
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] d;
    int h0, r0;
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", IW'(busy), 0);
    chk(irq == 1'b0, "R1 irq", IW'(irq), 0);
    chk(xfer_valid == 1'b0, "R1 xfer_valid", IW'(xfer_valid), 0);
    chk(dm_rd_en == 1'b0, "R1 dm_rd_en", IW'(dm_rd_en), 0);

    reg_wr(2'd0, 24'h000010);
    reg_rd(2'd0, d);
    chk(d == 24'h000010, "R9 pointer readback", IW'(d), IW'(24'h10));

    // three-descriptor chain, unknown control bits set, with backpressure
    put_desc(12'h010, 24'h000100, 24'hABCDEF, 24'h000040, 24'h001234, 24'h000008, 24'h000100, 24'h000FFF);
    put_desc(12'h100, 24'h0002F0, 24'h00220C, 24'h000004, 24'h00ABCD, 24'h111111, 24'h222222, 24'h333333);
    put_desc(12'h2F0, 24'h004ABC, 24'hFFC3F3, 24'h800000, 24'h7FFFFF, 24'h000001, 24'h000002, 24'h000003);
    bp_en = 1'b1;
    reg_wr(2'd1, 24'h000001);
    reg_wr(2'd0, 24'h000555);  // R8: pointer write while busy
    reg_rd(2'd0, d);
    chk(d == 24'h000010, "R8 pointer write ignored while busy", IW'(d), IW'(24'h10));
    reg_wr(2'd1, 24'h000001);  // R8: start while busy
    reg_rd(2'd2, d);
    chk(d[0] == 1'b1, "R9 status busy bit", IW'(d), IW'(24'h1));
    wait_idle();
    bp_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R6 irq after end of list", IW'(irq), 1);
    chk(hs_cnt == 3, "R5 chained request count", IW'(hs_cnt), 3);
    chk(addr_q.size() == 0 && exp_q.size() == 0, "R2/R8 all reads done, no extra", IW'(addr_q.size()), 0);
    reg_rd(2'd2, d);
    chk(d == 24'h000080, "R9 status flag set, not busy", IW'(d), IW'(24'h80));
    reg_rd(2'd0, d);
    chk(d == 24'h000ABC, "R5 pointer takes last link", IW'(d), IW'(24'hABC));
    r0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk(rd_cnt == r0, "R6 no reads after end of list", IW'(rd_cnt), IW'(r0));

    reg_wr(2'd2, 24'h00007F);
    @(negedge clk);
    chk(irq == 1'b1, "R7 write without bit 7 keeps flag", IW'(irq), 1);
    reg_wr(2'd2, 24'h000080);
    @(negedge clk);
    chk(irq == 1'b0, "R7 write-one clears flag", IW'(irq), 0);

    // set and clear in the same cycle
    manual = 1'b1;
    reg_wr(2'd0, 24'h000300);
    put_desc(12'h300, 24'h004123, 24'h000000, 24'h000010, 24'h000020, 24'h000030, 24'h000040, 24'h000050);
    h0 = hs_cnt;
    reg_wr(2'd1, 24'h000001);
    while (hs_cnt == h0) @(negedge clk);
    @(negedge clk);
    done_man = 1'b1; reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 24'h000080;
    @(negedge clk);
    done_man = 1'b0; reg_wr_en = 1'b0;
    chk(irq == 1'b1, "R7 set wins over simultaneous clear", IW'(irq), 1);
    chk(busy == 1'b0, "R6 busy falls on final completion", IW'(busy), 0);
    reg_rd(2'd2, d);
    chk(d == 24'h000080, "R7 status after collision", IW'(d), IW'(24'h80));
    reg_rd(2'd0, d);
    chk(d == 24'h000123, "R5 pointer after single descriptor", IW'(d), IW'(24'h123));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule